// File: doc/BRIEF.md
# Hash Accelerator Register Front-End

This block is the register shell and sequencer that sits between a simple 32-bit register port and a message-digest engine. Software configures an algorithm and options, programs a byte count, and streams message words into a sixteen-word input window. The block collects each 64-byte block and hands it to the engine. It raises input-ready, context-ready and output-ready as the operation moves along, and it exposes the result through a digest window whose visible size follows the selected algorithm. A separate operation turns a sixteen-word key, written into a key window, into a pre-processed key that is read back from that window.

The compression rounds are represented by a stub engine with a fixed latency and a simple, documented mixing rule. A front-end sequence can then be checked exactly. A soft reset, requested through the configuration register, clears every piece of state over a fixed number of cycles. A reset-done flag shows when that sequence has finished.

Register word addresses: 0x00 config (bit0 = soft reset), 0x01 status, 0x02 mode, 0x03 length, 0x04 digest count, 0x10-0x1F input window, 0x20-0x27 digest window, 0x30-0x3F key window. Reads are combinational while `bus_valid` is high and `bus_write` is low.

Top module: `hash_front`

## Requirements
- R1: Writing 1 to config bit0 starts a soft reset. Status bit0 (reset-done) then reads 0 for exactly RST_CYCLES cycles and 1 afterwards. Mode, length, digest count and key window read 0 after it, and status reads 0x3.
- R2: Status bit1 (context-ready) is 1 when idle or when a result is held. While it is 0, writes to mode (bits[2:0] algorithm, bit3 close, bit4 key-process), length, digest count and key window are ignored. Status after reset reads 0x3.
- R3: A length write with an accepted configuration and a non-zero byte count raises input-ready (status bit2) and clears output-ready.
- R4: Input-ready drops on the edge that takes the 16th word of a block. It stays low for exactly CORE_LAT cycles while the engine runs. Input-window writes made while it is low change nothing.
- R5: When the running byte total (4 per word) reaches the programmed length, the partial block is handed over. Its unwritten words count as zero.
- R6: A length that is not a multiple of 64 is rejected when the close bit is clear. Nothing starts and the current state is kept.
- R7: Algorithm codes 4 to 7 are invalid. A length write under them starts nothing, and output-ready stays low.
- R8: Each block B updates the eight digest words as D[i] = rotl1(D[i]) ^ B[i] ^ B[i+8], starting from zero. Algorithm codes 0,1,2,3 expose 4,5,7,8 digest words, and higher digest addresses read 0.
- R9: With the key-process bit set, a length write of 0 runs the engine for CORE_LAT cycles. Output-ready then rises, and every key-window word reads its written value XOR 0x36363636.
- R10: The digest count register is writable and grows by the block's byte count (4 per word) as each block completes.
- R11: Output-ready (status bit3) rises only after the final block has been processed. It falls on the next accepted length write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no read |
| ctx_ready | output | 1 | Context-ready: mode, length and key may be written |
| in_ready | output | 1 | Input-ready: input window accepts words |
| out_ready | output | 1 | Output-ready: result or processed key is valid |

## Verification
The bench sweeps all eight algorithm codes over a one-block message. This separates the four digest widths from each other and from the rejected codes. It then sweeps every word-aligned length from 4 to 64 bytes under the close option, plus an odd byte count, so the partial-block handover point and the zero filling are tried at each position. Two-block messages expose the input-ready gap and the block boundary. One of them carries a stray write during the engine run, which would shift that boundary if it were accepted. Key processing, writes refused while busy, and the soft-reset sweep close the run.

// File: rtl/hfe_pkg.sv
package hfe_pkg;
  localparam int WORD_W    = 32;
  localparam int BLK_WORDS = 16;
  localparam int DIG_WORDS = 8;
  localparam int ADDR_W    = 6;
  localparam int MODE_W    = 5;
  localparam int IDX_W     = $clog2(BLK_WORDS);
  localparam int CNT_W     = $clog2(BLK_WORDS + 1);

  typedef logic [WORD_W-1:0]    word_t;
  typedef word_t [BLK_WORDS-1:0] blk_t;
  typedef word_t [DIG_WORDS-1:0] dig_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_BUSY, ST_DONE} seq_state_t;

  localparam word_t KEY_PAD = 32'h3636_3636;

  localparam logic [ADDR_W-1:0] A_CFG  = 6'h00;
  localparam logic [ADDR_W-1:0] A_STAT = 6'h01;
  localparam logic [ADDR_W-1:0] A_MODE = 6'h02;
  localparam logic [ADDR_W-1:0] A_LEN  = 6'h03;
  localparam logic [ADDR_W-1:0] A_DCNT = 6'h04;

  localparam int MB_CLOSE = 3;
  localparam int MB_KEY   = 4;

  // visible digest words per algorithm code, 0 = invalid code
  function automatic logic [3:0] algo_words(input logic [2:0] code);
    case (code)
      3'd0:    algo_words = 4'd4;
      3'd1:    algo_words = 4'd5;
      3'd2:    algo_words = 4'd7;
      3'd3:    algo_words = 4'd8;
      default: algo_words = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/hfe_softreset.sv
module hfe_softreset #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic srst,
  output logic done
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (trig) begin
      busy_d = 1'b1;
      cnt_d  = CW'(RST_CYCLES - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign srst = busy_q;
  assign done = !busy_q;

  // R1: an accepted trigger drops reset-done on the following cycle
  p_trig_drops_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !busy_q) |=> !done)
    else $error("p_trig_drops_done_r1");
endmodule

// File: rtl/hfe_blockbuf.sv
module hfe_blockbuf
  import hfe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  word_t            wdata,
  output blk_t             blk,
  output logic [CNT_W-1:0] cnt
);
  blk_t             blk_q, blk_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    blk_d = blk_q;
    cnt_d = cnt_q;
    if (clr) begin
      blk_d = '0;
      cnt_d = '0;
    end else if (we) begin
      blk_d[idx] = wdata;
      cnt_d      = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
      cnt_q <= '0;
    end else begin
      blk_q <= blk_d;
      cnt_q <= cnt_d;
    end
  end

  assign blk = blk_q;
  assign cnt = cnt_q;

  // R4: a block never holds more than its word count
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(BLK_WORDS))
    else $error("p_cnt_bound_r4");
endmodule

// File: rtl/hfe_stub_core.sv
module hfe_stub_core
  import hfe_pkg::*;
#(
  parameter int LAT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             go,
  input  logic             op_key,
  input  logic             init,
  input  blk_t             blk,
  input  logic             key_we,
  input  logic [IDX_W-1:0] key_idx,
  input  word_t            key_wdata,
  output dig_t             dig,
  output blk_t             key,
  output logic             busy,
  output logic             done
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  logic          busy_q, busy_d;
  logic          op_q, op_d;
  logic [CW-1:0] cnt_q, cnt_d;
  dig_t          dig_q, dig_d, mixed;
  blk_t          key_q, key_d, padded;

  generate
    for (genvar g = 0; g < DIG_WORDS; g++) begin : g_mix
      assign mixed[g] = {dig_q[g][WORD_W-2:0], dig_q[g][WORD_W-1]}
                        ^ blk[g] ^ blk[g + DIG_WORDS];
    end
    for (genvar g = 0; g < BLK_WORDS; g++) begin : g_pad
      assign padded[g] = key_q[g] ^ KEY_PAD;
    end
  endgenerate

  assign done = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    op_d   = op_q;
    cnt_d  = cnt_q;
    dig_d  = dig_q;
    key_d  = key_q;
    if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (go) begin
      busy_d = 1'b1;
      op_d   = op_key;
      cnt_d  = CW'(LAT - 1);
    end
    if (init)               dig_d = '0;
    else if (done && !op_q) dig_d = mixed;
    if (key_we)             key_d[key_idx] = key_wdata;
    else if (done && op_q)  key_d = padded;
    if (clr) begin
      busy_d = 1'b0;
      op_d   = 1'b0;
      cnt_d  = '0;
      dig_d  = '0;
      key_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= 1'b0;
      cnt_q  <= '0;
      dig_q  <= '0;
      key_q  <= '0;
    end else begin
      busy_q <= busy_d;
      op_q   <= op_d;
      cnt_q  <= cnt_d;
      dig_q  <= dig_d;
      key_q  <= key_d;
    end
  end

  assign dig  = dig_q;
  assign key  = key_q;
  assign busy = busy_q;

  // R4: the sequencer only launches an idle engine
  p_go_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy_q)
    else $error("p_go_when_idle_r4");
endmodule

// File: rtl/hash_front.sv
module hash_front
  import hfe_pkg::*;
#(
  parameter int CORE_LAT   = 6,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              ctx_ready,
  output logic              in_ready,
  output logic              out_ready
);
  seq_state_t        state_q, state_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  word_t             len_q, len_d, total_q, total_d, dcnt_q, dcnt_d;
  logic              opk_q, opk_d;

  logic             srst, rst_done;
  blk_t             blk, key;
  dig_t             dig;
  logic [CNT_W-1:0] blk_cnt;
  logic             core_busy, core_done;

  // address decode
  logic is_cfg, is_mode, is_len, is_dcnt, is_data, is_dig, is_key;
  assign is_cfg  = bus_addr == A_CFG;
  assign is_mode = bus_addr == A_MODE;
  assign is_len  = bus_addr == A_LEN;
  assign is_dcnt = bus_addr == A_DCNT;
  assign is_data = bus_addr[5:4] == 2'b01;
  assign is_dig  = bus_addr[5:3] == 3'b100;
  assign is_key  = bus_addr[5:4] == 2'b11;

  logic ctx_rdy, in_rdy, out_rdy, wr;
  assign ctx_rdy = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign in_rdy  = state_q == ST_LOAD;
  assign out_rdy = state_q == ST_DONE;
  assign wr      = bus_valid && bus_write && !srst;

  logic mode_we, len_we, key_we, dcnt_we, data_we, soft_trig;
  assign mode_we   = wr && is_mode && ctx_rdy;
  assign len_we    = wr && is_len  && ctx_rdy;
  assign key_we    = wr && is_key  && ctx_rdy;
  assign dcnt_we   = wr && is_dcnt && ctx_rdy;
  assign data_we   = wr && is_data && in_rdy;
  assign soft_trig = bus_valid && bus_write && is_cfg && bus_wdata[0];

  logic algo_ok, len_zero, key_start, hash_start, last_word, core_go;
  assign algo_ok    = algo_words(mode_q[2:0]) != 4'd0;
  assign len_zero   = bus_wdata == '0;
  assign key_start  = len_we && algo_ok && mode_q[MB_KEY] && len_zero;
  assign hash_start = len_we && algo_ok && !key_start
                      && (mode_q[MB_CLOSE] || (bus_wdata[5:0] == 6'd0));
  assign last_word  = data_we && ((blk_cnt == CNT_W'(BLK_WORDS - 1))
                      || ({1'b0, total_q} + 33'd4 >= {1'b0, len_q}));
  assign core_go    = key_start || (hash_start && len_zero) || last_word;

  // next-state logic
  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    len_d   = len_q;
    total_d = total_q;
    dcnt_d  = dcnt_q;
    opk_d   = opk_q;
    if (mode_we) mode_d = bus_wdata[MODE_W-1:0];
    if (len_we)  len_d  = bus_wdata;
    if (dcnt_we)                dcnt_d = bus_wdata;
    else if (core_done && !opk_q) dcnt_d = dcnt_q + 32'({blk_cnt, 2'b00});
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (key_start) begin
          opk_d   = 1'b1;
          state_d = ST_BUSY;
        end else if (hash_start) begin
          opk_d   = 1'b0;
          total_d = '0;
          state_d = len_zero ? ST_BUSY : ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (data_we)   total_d = total_q + 32'd4;
        if (last_word) state_d = ST_BUSY;
      end
      ST_BUSY: begin
        if (core_done) state_d = (opk_q || (total_q >= len_q)) ? ST_DONE : ST_LOAD;
      end
      default: state_d = ST_IDLE;
    endcase
    if (srst) begin
      state_d = ST_IDLE;
      mode_d  = '0;
      len_d   = '0;
      total_d = '0;
      dcnt_d  = '0;
      opk_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      len_q   <= '0;
      total_q <= '0;
      dcnt_q  <= '0;
      opk_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      len_q   <= len_d;
      total_q <= total_d;
      dcnt_q  <= dcnt_d;
      opk_q   <= opk_d;
    end
  end

  hfe_softreset #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk  (clk),
    .rst_n(rst_n),
    .trig (soft_trig),
    .srst (srst),
    .done (rst_done)
  );

  hfe_blockbuf u_buf (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (srst || core_done || hash_start),
    .we   (data_we),
    .idx  (bus_addr[IDX_W-1:0]),
    .wdata(bus_wdata),
    .blk  (blk),
    .cnt  (blk_cnt)
  );

  hfe_stub_core #(.LAT(CORE_LAT)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (srst),
    .go       (core_go),
    .op_key   (key_start),
    .init     (hash_start),
    .blk      (blk),
    .key_we   (key_we),
    .key_idx  (bus_addr[IDX_W-1:0]),
    .key_wdata(bus_wdata),
    .dig      (dig),
    .key      (key),
    .busy     (core_busy),
    .done     (core_done)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      if (bus_addr == A_STAT)
        bus_rdata = {28'd0, out_rdy, in_rdy, ctx_rdy, rst_done};
      else if (is_mode) bus_rdata = 32'(mode_q);
      else if (is_len)  bus_rdata = len_q;
      else if (is_dcnt) bus_rdata = dcnt_q;
      else if (is_dig) begin
        if ({1'b0, bus_addr[2:0]} < algo_words(mode_q[2:0]))
          bus_rdata = dig[bus_addr[2:0]];
      end else if (is_key) bus_rdata = key[bus_addr[IDX_W-1:0]];
    end
  end

  assign ctx_ready = ctx_rdy;
  assign in_ready  = in_rdy;
  assign out_ready = out_rdy;

  // R11: a result appears only on an engine completion
  p_out_after_core_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_rdy) |-> $past(core_done))
    else $error("p_out_after_core_r11");

  // R4: input-ready only falls on a block handover or a soft reset
  p_in_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_rdy) |-> ($past(last_word) || $past(srst)))
    else $error("p_in_fall_r4");

  // R7: an invalid algorithm code leaves the sequencer where it was
  p_bad_algo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (len_we && !algo_ok) |=> (state_q == $past(state_q)) && !core_busy)
    else $error("p_bad_algo_r7");

  // R6: a misaligned length without close never opens the input window
  p_misaligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (len_we && algo_ok && !mode_q[MB_CLOSE] && !mode_q[MB_KEY]
     && (bus_wdata[5:0] != 6'd0)) |=> !in_rdy)
    else $error("p_misaligned_r6");

  // R4: data writes outside the input window phase leave the buffer count alone
  p_data_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && is_data && !in_rdy && !core_done && !srst && !hash_start)
    |=> $stable(blk_cnt))
    else $error("p_data_ignored_r4");
endmodule

// File: tb/tb_hash_front.sv
module tb_hash_front;
  localparam int CLK_PERIOD = 10;
  localparam int LAT  = 6;
  localparam int RSTC = 4;
  localparam logic [5:0] A_CFG = 6'h00, A_STAT = 6'h01, A_MODE = 6'h02,
                         A_LEN = 6'h03, A_DCNT = 6'h04, A_DATA = 6'h10,
                         A_DIG = 6'h20, A_KEY  = 6'h30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ctx_ready, in_ready, out_ready;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hash_front #(.CORE_LAT(LAT), .RST_CYCLES(RSTC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ctx_ready(ctx_ready), .in_ready(in_ready), .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  function automatic int nwords(input int algo);
    case (algo)
      0: return 4;
      1: return 5;
      2: return 7;
      3: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] dw(input int seed, input int k);
    return (32'h9E37_79B9 * 32'(seed + 1)) ^ (32'(k) * 32'h0101_0101) ^ 32'(k << 20);
  endfunction

  function automatic logic [31:0] kv(input int i);
    return 32'h0102_0304 * 32'(i + 1);
  endfunction

  task automatic hash_case(input int algo, input bit close, input int len,
                           input int seed, input bit junk, input bit measure,
                           input string tag);
    logic [31:0] b[16];
    logic [31:0] d[8];
    logic [31:0] v, exp;
    int nw, cnt, t;
    for (int i = 0; i < 16; i++) b[i] = '0;
    for (int i = 0; i < 8; i++) d[i] = '0;
    wr(A_MODE, (32'(close) << 3) | 32'(algo));
    wr(A_LEN, 32'(len));
    chk(in_ready == 1'b1, "R3 input-ready after length", 32'(in_ready), 1);
    chk(out_ready == 1'b0, "R11 output-ready cleared", 32'(out_ready), 0);
    nw = (len + 3) / 4;
    for (int k = 0; k < nw; k++) begin
      t = 0;
      while (!in_ready && t < 200) begin @(negedge clk); t++; end
      if (k == nw - 1) chk(!out_ready, "R11 no result before last block", 32'(out_ready), 0);
      v = dw(seed, k);
      wr(A_DATA + 6'(k % 16), v);
      b[k % 16] = v;
      if ((k % 16 == 15) || (k == nw - 1)) begin
        for (int i = 0; i < 8; i++) d[i] = {d[i][30:0], d[i][31]} ^ b[i] ^ b[i + 8];
        for (int i = 0; i < 16; i++) b[i] = '0;
        if (measure && k == 15) begin
          cnt = 0;
          @(negedge clk);
          while (!in_ready && cnt < 100) begin cnt++; @(negedge clk); end
          chk(cnt == LAT, "R4 input-ready gap", 32'(cnt), 32'(LAT));
        end
        if (junk && k == 15) wr(A_DATA, 32'hDEAD_BEEF);
      end
    end
    t = 0;
    while (!out_ready && t < 2000) begin @(negedge clk); t++; end
    chk(out_ready, "R11 output-ready after final block", 32'(out_ready), 1);
    for (int i = 0; i < 8; i++) begin
      rd(A_DIG + 6'(i), v);
      exp = (i < nwords(algo)) ? d[i] : 32'h0;
      chk(v == exp, tag, v, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 / R1: idle state after reset
    rd(A_STAT, v);
    chk(v == 32'h3, "R2 status after reset", v, 32'h3);

    // R7: invalid algorithm codes start nothing
    for (int a = 4; a < 8; a++) begin
      wr(A_MODE, 32'h8 | 32'(a));
      wr(A_LEN, 32'd64);
      repeat (LAT + 4) @(negedge clk);
      chk(!in_ready && !out_ready, "R7 invalid algorithm idle",
          {30'd0, in_ready, out_ready}, 0);
    end

    // R8: every valid algorithm over one full block
    for (int a = 0; a < 4; a++) hash_case(a, 1'b0, 64, a, 1'b0, 1'b0, "R8 digest word");

    // R6: misaligned length without close
    wr(A_MODE, 32'h3);
    wr(A_LEN, 32'd60);
    chk(!in_ready, "R6 misaligned length rejected", 32'(in_ready), 0);
    chk(out_ready, "R6 previous result kept", 32'(out_ready), 1);

    // R5: partial final blocks at every word position
    for (int k = 1; k <= 16; k++)
      hash_case(3, 1'b1, 4 * k, 10 + k, 1'b0, 1'b0, "R5 partial block digest");
    hash_case(1, 1'b1, 6, 40, 1'b0, 1'b0, "R5 odd length digest");

    // R4: two blocks with the engine gap measured
    hash_case(2, 1'b0, 128, 50, 1'b0, 1'b1, "R4 two block digest");

    // R10 with R4: preset count, stray write during engine run
    wr(A_DCNT, 32'd64);
    hash_case(3, 1'b0, 128, 60, 1'b1, 1'b0, "R4 stray write ignored digest");
    rd(A_DCNT, v);
    chk(v == 32'd192, "R10 digest count", v, 32'd192);

    // R9: key pre-processing
    wr(A_MODE, 32'h10);
    for (int i = 0; i < 16; i++) wr(A_KEY + 6'(i), kv(i));
    wr(A_LEN, 32'd0);
    cnt = 0;
    @(negedge clk);
    while (!out_ready && cnt < 100) begin cnt++; @(negedge clk); end
    chk(cnt == LAT, "R9 key processing latency", 32'(cnt), 32'(LAT));
    for (int i = 0; i < 16; i++) begin
      rd(A_KEY + 6'(i), v);
      chk(v == (kv(i) ^ 32'h3636_3636), "R9 processed key word", v, kv(i) ^ 32'h3636_3636);
    end

    // R2: configuration writes refused while a message is loading
    wr(A_MODE, 32'h3);
    wr(A_LEN, 32'd128);
    wr(A_DATA, 32'h1234_5678);
    wr(A_MODE, 32'h1);
    rd(A_MODE, v);
    chk(v == 32'h3, "R2 mode write ignored", v, 32'h3);
    wr(A_KEY, 32'hFFFF_0000);
    rd(A_KEY, v);
    chk(v == (kv(0) ^ 32'h3636_3636), "R2 key write ignored", v, kv(0) ^ 32'h3636_3636);
    rd(A_STAT, v);
    chk(v == 32'h5, "R2 status while loading", v, 32'h5);

    // R1: soft reset
    wr(A_CFG, 32'h1);
    cnt = 0;
    do begin
      rd(A_STAT, v);
      if (!v[0]) cnt++;
    end while (!v[0] && cnt < 50);
    chk(cnt == RSTC, "R1 reset-done low cycles", 32'(cnt), 32'(RSTC));
    rd(A_MODE, v);
    chk(v == 0, "R1 mode cleared", v, 0);
    rd(A_DCNT, v);
    chk(v == 0, "R1 digest count cleared", v, 0);
    rd(A_LEN, v);
    chk(v == 0, "R1 length cleared", v, 0);
    rd(A_KEY, v);
    chk(v == 0, "R1 key cleared", v, 0);
    rd(A_STAT, v);
    chk(v == 32'h3, "R1 status after soft reset", v, 32'h3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule